// File: doc/BRIEF.md
# Self-Timed Page Programming Sequencer

This block sits behind a serial command front-end and turns decoded write commands into self-timed programming of a 128 x 16 word memory. It handles three kinds of command: a single-word write, a page write of up to four words, and a write-all that fills the whole array with one word. The incoming words are collected in a four-entry page buffer. Programming starts when chip select falls. Every target address is checked against the write-protect boundary before a cycle is allowed to start. A busy timer, counted in clock cycles, stands in for the physical programming time.

While a cycle runs, the block ignores new commands and data. It reports busy or ready on a status bit that the serial interface drives onto its data line while chip select is high. After reset, the block first sweeps the array to all ones, one word per cycle, and it reports busy during that sweep. A synchronous read port gives the serial front-end access to the stored words. The busy time must be at least as long as the array depth.

Top module: `page_prog_seq`

## Requirements
- R1: After reset the block is busy while it sweeps every word of the array to FFFFh, and then it becomes idle with every word reading FFFFh.
- R2: A command of kind 2'b01 (single word), once chip select falls with at least one word received, writes that word to the command address. busy_o is then high for exactly PROG_CYCLES clock cycles, starting in the cycle after chip select is seen low.
- R3: A command of kind 2'b11 (page) stores each received word at the next slot of the four-word page. The slot index is the low two address bits, incremented after each word and wrapping modulo 4, while the upper five address bits stay fixed. A fifth word therefore replaces the first.
- R4: An address is protected when prot_clear_i is 0 and the address is greater than or equal to prot_base_i. A single write to a protected address is skipped. A page write is skipped whole if any slot it received a word for is protected. A skipped command starts no busy period.
- R5: A command of kind 2'b00 (write all) writes its word to all 128 addresses. It is accepted only when prot_clear_i is 1.
- R6: No command writes anything, or starts a busy period, unless wen_latch_i is 1 when chip select falls.
- R7: If chip select falls before one complete data word has been received, the command is discarded and no busy period starts.
- R8: While busy, commands, data words and chip select falls have no effect on the array, and they start no further busy period.
- R9: With chip select high, q_oe_o is 1. q_o is then 0 while busy, and q_o turns to 1 once programming has completed.
- R10: Once ready has been shown, q_oe_o stays high with q_o at 1 until a start bit is reported or chip select goes low. Either of these drops q_oe_o.
- R11: For single and write-all commands, only the first data word is used, and later words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select level, synchronised to clk |
| start_bit_i | input | 1 | Pulse: front-end decoded a new start bit |
| cmd_valid_i | input | 1 | Pulse: decoded write command present |
| cmd_kind_i | input | 2 | 00 write all, 01 single, 11 page, 10 none |
| cmd_addr_i | input | 7 | Command word address |
| word_valid_i | input | 1 | Pulse: a full 16-bit data word received |
| word_data_i | input | 16 | Received data word |
| wen_latch_i | input | 1 | Write-enable latch state |
| prot_base_i | input | 7 | First protected address |
| prot_clear_i | input | 1 | 1 when protection is cleared (no area protected) |
| rd_addr_i | input | 7 | Read address |
| rd_data_o | output | 16 | Read data, one cycle after the address |
| busy_o | output | 1 | Programming or reset sweep in progress |
| q_oe_o | output | 1 | Status bit is to be driven on the data line |
| q_o | output | 1 | Status value: 0 busy, 1 ready |

## Verification
The bench runs directed commands that separate page wrap from a linear increment: a page write starting at offset 2, and a five-word page in which the last word must land on the first slot. Protection is tested with the boundary placed just inside and just outside the written slots. This shows whether the check covers only the words actually received, or the whole page. A seeded random mix of kinds, word counts, enable states and protect settings is then compared against a bench model of the array. Each command is also checked for whether a busy period occurs and how long it lasts. The status sequence is exercised busy, then ready, then a start bit, so that a status output that lags or sticks can be told apart from a correct one.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [1:0] {
    K_ALL  = 2'b00,
    K_ONE  = 2'b01,
    K_NONE = 2'b10,
    K_PAGE = 2'b11
  } wkind_t;

  typedef enum logic [1:0] {
    S_INIT,
    S_IDLE,
    S_COLLECT,
    S_PROG
  } st_t;
endpackage

// File: rtl/pps_prot_chk.sv
module pps_prot_chk #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 2
) (
  input  logic [ADDR_W-PAGE_W-1:0] page_i,
  input  logic [(1<<PAGE_W)-1:0]   mask_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic                     clear_i,
  output logic                     hit_o
);
  localparam int PAGE = 1 << PAGE_W;

  logic [PAGE-1:0] hits;

  // one comparator per page slot, qualified by the slot having data
  for (genvar i = 0; i < PAGE; i++) begin : g_slot
    assign hits[i] = mask_i[i] & ~clear_i & ({page_i, PAGE_W'(i)} >= base_i);
  end

  assign hit_o = |hits;
endmodule

// File: rtl/pps_page_buf.sv
module pps_page_buf #(
  parameter int DATA_W = 16,
  parameter int PAGE_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr_i,
  input  logic                   we_i,
  input  logic [PAGE_W-1:0]      wslot_i,
  input  logic [DATA_W-1:0]      wdata_i,
  input  logic [PAGE_W-1:0]      rslot_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [(1<<PAGE_W)-1:0] mask_o
);
  localparam int PAGE = 1 << PAGE_W;

  logic [DATA_W-1:0] words [PAGE];

  always_ff @(posedge clk) begin
    if (we_i) words[wslot_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) mask_o <= '0;
    else if (we_i)    mask_o[wslot_i] <= 1'b1;
  end

  assign rdata_o = words[rslot_i];

  // R3
  buf_mask_chk: assert property (@(posedge clk) disable iff (rst)
    we_i |=> mask_o[$past(wslot_i)]);
endmodule

// File: rtl/pps_busy_timer.sv
module pps_busy_timer #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  output logic last_o
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (load_i) begin
      active <= 1'b1;
      cnt    <= CW'(CYCLES - 1);
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign last_o = active & (cnt == '0);

  // R2
  timer_reload_chk: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !active);
endmodule

// File: rtl/pps_mem_array.sv
module pps_mem_array #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // single write port, registered read: maps onto a block RAM
  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
    rdata_o <= cells[raddr_i];
  end
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
  import pps_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 16,
  parameter int PAGE_W      = 2,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic              start_bit_i,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_kind_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic              word_valid_i,
  input  logic [DATA_W-1:0] word_data_i,
  input  logic              wen_latch_i,
  input  logic [ADDR_W-1:0] prot_base_i,
  input  logic              prot_clear_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              busy_o,
  output logic              q_oe_o,
  output logic              q_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int HI_W  = ADDR_W - PAGE_W;
  localparam int WC_W  = ADDR_W + 1;

  st_t               st;
  wkind_t            kind_q;
  logic [HI_W-1:0]   page_q;
  logic [PAGE_W-1:0] ptr;
  logic [WC_W-1:0]   wc;
  logic              cs_q;
  logic              pend;

  logic [PAGE-1:0]   mask;
  logic [DATA_W-1:0] buf_dout;
  logic              prot_hit;
  logic              tmr_last;

  logic              cs_fall, cmd_take, word_take, accept;
  logic [PAGE_W-1:0] wr_slot, rd_slot;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;

  assign busy_o    = (st == S_INIT) || (st == S_PROG);
  assign cs_fall   = cs_q & ~cs_i;
  assign cmd_take  = (st == S_IDLE) && cmd_valid_i && (cmd_kind_i != K_NONE);
  assign word_take = (st == S_COLLECT) && word_valid_i &&
                     ((kind_q == K_PAGE) || (mask == '0));
  assign wr_slot   = (kind_q == K_ALL) ? '0 : ptr;
  assign rd_slot   = (kind_q == K_ALL) ? '0 : wc[PAGE_W-1:0];
  assign accept    = (st == S_COLLECT) && cs_fall && (|mask) && wen_latch_i &&
                     ((kind_q == K_ALL) ? prot_clear_i : !prot_hit);

  pps_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .clr_i   (cmd_take),
    .we_i    (word_take),
    .wslot_i (wr_slot),
    .wdata_i (word_data_i),
    .rslot_i (rd_slot),
    .rdata_o (buf_dout),
    .mask_o  (mask)
  );

  pps_prot_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_prot (
    .page_i  (page_q),
    .mask_i  (mask),
    .base_i  (prot_base_i),
    .clear_i (prot_clear_i),
    .hit_o   (prot_hit)
  );

  pps_busy_timer #(.CYCLES(PROG_CYCLES)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .load_i (accept),
    .last_o (tmr_last)
  );

  // write port: reset sweep, page slots, or whole-array fill
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = wc[ADDR_W-1:0];
    mem_wdata = '1;
    if (st == S_INIT) begin
      mem_we = 1'b1;
    end else if (st == S_PROG) begin
      mem_wdata = buf_dout;
      if (kind_q == K_ALL) begin
        mem_we = ~wc[ADDR_W];
      end else begin
        mem_we    = (wc < WC_W'(PAGE)) && mask[wc[PAGE_W-1:0]];
        mem_waddr = {page_q, wc[PAGE_W-1:0]};
      end
    end
  end

  pps_mem_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_INIT;
      kind_q <= K_NONE;
      page_q <= '0;
      ptr    <= '0;
      wc     <= '0;
      cs_q   <= 1'b0;
      pend   <= 1'b0;
      q_oe_o <= 1'b0;
      q_o    <= 1'b0;
    end else begin
      cs_q   <= cs_i;
      q_oe_o <= cs_i & (busy_o | pend);
      q_o    <= ~busy_o;
      if (!busy_o && start_bit_i) pend <= 1'b0;
      unique case (st)
        S_INIT: begin
          wc <= wc + 1'b1;
          if (wc == WC_W'(DEPTH - 1)) st <= S_IDLE;
        end
        S_IDLE: begin
          if (cmd_take) begin
            kind_q <= wkind_t'(cmd_kind_i);
            page_q <= cmd_addr_i[ADDR_W-1:PAGE_W];
            ptr    <= cmd_addr_i[PAGE_W-1:0];
            st     <= S_COLLECT;
          end
        end
        S_COLLECT: begin
          if (word_take && kind_q == K_PAGE) ptr <= ptr + 1'b1;
          if (cs_fall) begin
            if (accept) begin
              st   <= S_PROG;
              wc   <= '0;
              pend <= 1'b1;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_PROG: begin
          if (!wc[ADDR_W]) wc <= wc + 1'b1;
          if (tmr_last) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6
  accept_wen_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(wen_latch_i));

  // R5
  all_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy_o) && kind_q == K_ALL) |-> $past(prot_clear_i));

  // R4
  prot_write_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_we && st == S_PROG && kind_q != K_ALL) |->
      (prot_clear_i || mem_waddr < prot_base_i));

  // R9
  q_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (q_oe_o && $past(busy_o)) |-> !q_o);

  // R10
  q_cs_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cs_i) |-> !q_oe_o);
endmodule

// File: tb/sim_page_prog_seq.sv
module sim_page_prog_seq;
  localparam int CLK_NS = 10;
  localparam int P      = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 1'b0, sb = 1'b0, cv = 1'b0, wv = 1'b0;
  logic [1:0]  ck = 2'b10;
  logic [6:0]  ca = '0, pb = '0, ra = '0;
  logic [15:0] wd = '0;
  logic        wen = 1'b0, pc = 1'b1;
  logic [15:0] rd;
  logic        busy, qoe, q;

  int checks = 0;
  int errors = 0;
  logic [15:0] mdl [128];
  logic [15:0] ws [5];

  always #(CLK_NS/2) clk = ~clk;

  page_prog_seq u0 (
    .clk(clk), .rst(rst), .cs_i(cs), .start_bit_i(sb), .cmd_valid_i(cv),
    .cmd_kind_i(ck), .cmd_addr_i(ca), .word_valid_i(wv), .word_data_i(wd),
    .wen_latch_i(wen), .prot_base_i(pb), .prot_clear_i(pc), .rd_addr_i(ra),
    .rd_data_o(rd), .busy_o(busy), .q_oe_o(qoe), .q_o(q)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rdw(input logic [6:0] a, output logic [15:0] d);
    ra = a;
    tick();
    d = rd;
  endtask

  task automatic issue(input logic [1:0] k, input logic [6:0] a, input int n);
    cs = 1; tick();
    cv = 1; ck = k; ca = a; tick();
    cv = 0;
    for (int i = 0; i < n; i++) begin
      wv = 1; wd = ws[i]; tick();
    end
    wv = 0; cs = 0; tick();
  endtask

  task automatic wait_idle(output int c);
    c = 0;
    while (busy && c < 1000) begin c++; tick(); end
  endtask

  // expected outcome from the requirements, updating the array model
  task automatic predict(input logic [1:0] k, input logic [6:0] a, input int n, output bit ok);
    logic [15:0] pbuf [4];
    bit   [3:0]  m;
    bit          hit;
    m = '0; hit = 0;
    for (int i = 0; i < n; i++) begin
      if (k == 2'b11) begin
        pbuf[(a[1:0] + i) % 4] = ws[i]; m[(a[1:0] + i) % 4] = 1;
      end else if (i == 0) begin
        int off = (k == 2'b00) ? 0 : int'(a[1:0]);
        pbuf[off] = ws[0]; m[off] = 1;
      end
    end
    for (int j = 0; j < 4; j++)
      if (m[j] && !pc && {a[6:2], 2'(j)} >= pb) hit = 1;
    ok = (m != 0) && wen && ((k == 2'b00) ? pc : !hit);
    if (ok) begin
      if (k == 2'b00) for (int j = 0; j < 128; j++) mdl[j] = pbuf[0];
      else for (int j = 0; j < 4; j++) if (m[j]) mdl[{a[6:2], 2'(j)}] = pbuf[j];
    end
  endtask

  task automatic run_cmd(input logic [1:0] k, input logic [6:0] a, input int n, input string tag);
    bit ok; int c; logic [15:0] d;
    predict(k, a, n, ok);
    issue(k, a, n);
    wait_idle(c);
    check(c == (ok ? P : 0), {tag, " busy length"}, c, ok ? P : 0);
    for (int j = 0; j < 4; j++) begin
      rdw({a[6:2], 2'(j)}, d);
      check(d == mdl[{a[6:2], 2'(j)}], {tag, " page data"}, d, mdl[{a[6:2], 2'(j)}]);
    end
    if (k == 2'b00) begin
      for (int j = 0; j < 128; j += 17) begin
        rdw(7'(j), d);
        check(d == mdl[j], {tag, " array data"}, d, mdl[j]);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int c; logic [15:0] d; bit ok;
    void'($urandom(32'd4711));
    for (int j = 0; j < 128; j++) mdl[j] = 16'hFFFF;
    repeat (4) tick();
    rst = 0; tick();
    // R1: sweep then all ones
    check(busy == 1, "R1 busy during sweep", busy, 1);
    check(qoe == 0, "R1 status idle at reset", qoe, 0);
    wait_idle(c);
    check(c > 100 && c < 200, "R1 sweep length", c, 128);
    begin
      int bad = 0;
      for (int j = 0; j < 128; j++) begin rdw(7'(j), d); if (d != 16'hFFFF) bad++; end
      check(bad == 0, "R1 array all ones", bad, 0);
    end

    // R6: no write without enable
    wen = 0; ws[0] = 16'h1234;
    run_cmd(2'b01, 7'h13, 1, "R6");
    wen = 1;
    // R2: single write
    ws[0] = 16'hA5A5;
    run_cmd(2'b01, 7'h13, 1, "R2");
    // R11: extra words ignored
    ws[0] = 16'h0F0F; ws[1] = 16'hDEAD;
    run_cmd(2'b01, 7'h16, 2, "R11");
    // R3: page wrap from offset 2
    ws[0] = 16'h1111; ws[1] = 16'h2222; ws[2] = 16'h3333; ws[3] = 16'h4444;
    run_cmd(2'b11, 7'h22, 4, "R3");
    // R3: fifth word replaces first slot
    ws[4] = 16'h5555;
    run_cmd(2'b11, 7'h30, 5, "R3 fifth");
    // R4: protection boundaries
    pc = 0; pb = 7'h41; ws[0] = 16'hBEEF; ws[1] = 16'hCAFE;
    run_cmd(2'b11, 7'h40, 2, "R4 page rejected");
    run_cmd(2'b01, 7'h41, 1, "R4 single rejected");
    run_cmd(2'b01, 7'h40, 1, "R4 single below");
    pb = 7'h42;
    run_cmd(2'b11, 7'h40, 2, "R4 page below boundary");
    // R7: no full word
    run_cmd(2'b01, 7'h08, 0, "R7");
    run_cmd(2'b11, 7'h08, 0, "R7 page");
    // R5: write all
    ws[0] = 16'h5A5A;
    run_cmd(2'b00, 7'h00, 1, "R5 protected");
    pc = 1;
    run_cmd(2'b00, 7'h00, 1, "R5 cleared");

    // R9 / R10: status sequence
    ws[0] = 16'h7777;
    predict(2'b01, 7'h05, 1, ok);
    issue(2'b01, 7'h05, 1);
    cs = 1; tick(); tick();
    check(qoe == 1 && q == 0, "R9 busy status", {qoe, q}, 2'b10);
    wait_idle(c);
    tick(); tick();
    check(qoe == 1 && q == 1, "R9 ready status", {qoe, q}, 2'b11);
    repeat (3) tick();
    check(qoe == 1 && q == 1, "R10 ready held", {qoe, q}, 2'b11);
    sb = 1; tick(); sb = 0; tick(); tick();
    check(qoe == 0, "R10 start bit drops status", qoe, 0);
    cs = 0; tick();

    // R8: input during busy ignored
    ws[0] = 16'h0102;
    predict(2'b01, 7'h50, 1, ok);
    issue(2'b01, 7'h50, 1);
    ws[0] = 16'h9999;
    issue(2'b01, 7'h51, 1);
    wait_idle(c);
    repeat (3) tick();
    check(busy == 0, "R8 no second cycle", busy, 0);
    rdw(7'h51, d);
    check(d == mdl[7'h51], "R8 ignored write", d, mdl[7'h51]);
    rdw(7'h50, d);
    check(d == mdl[7'h50], "R8 first write", d, mdl[7'h50]);

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [1:0] k;
      int r = $urandom_range(0, 19);
      k = (r == 0) ? 2'b00 : (r < 9) ? 2'b01 : 2'b11;
      wen = ($urandom_range(0, 3) != 0);
      pc  = $urandom_range(0, 1);
      pb  = 7'($urandom);
      for (int i = 0; i < 5; i++) ws[i] = 16'($urandom);
      run_cmd(k, 7'($urandom), $urandom_range(0, 5), "R3 R4 random");
    end

    // final sweep
    begin
      int bad = 0;
      for (int j = 0; j < 128; j++) begin rdw(7'(j), d); if (d != mdl[j]) bad++; end
      check(bad == 0, "R2 final array", bad, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule